// File: doc/BRIEF.md
# Single-Wire Parity Frame Transceiver

This block is the master side of a one-wire, master-clocked programming link. It generates the serial clock and shares one data line for both directions. The master drives a bit while the clock is low, raises the clock, and reads the line back during the high phase. The line is modelled as a wired-AND: the level that the block reads is its own drive combined with the target's drive. When the block holds the line high, the target can pull it low to reply.

All work enters through one command stream of four operations:
- **Send** transmits a byte as a 12-bit frame.
- **Receive** clocks a 16-bit window with the line held high and decodes the target's reply frame from it.
- **Preamble** holds the line high for 16 clocks before the first frame.
- **Link test** drives 0 and then 1 to confirm that the shared data path reads back both levels.

The command port uses valid/ready. `cmd_ready` is high only while the block is idle. A command is taken on the cycle where `cmd_valid` and `cmd_ready` are both high. The source must hold `cmd_valid`, `cmd_op` and `cmd_data` steady until that cycle.

Receive and link-test results come back as a one-cycle strobe with a data byte and an error code. There is no back-pressure on results. The clock half-period, `half_div+1` system cycles, must stay constant while a command runs.

Top module: `sdl_xcvr`

## Requirements
- R1: A Send command (`cmd_op`=0) emits 12 bit times on `line_o`, one per rising `sck_o`, in this order: a start bit of 0, the eight bits of `cmd_data` least significant first, a parity bit, then two stop bits of 1.
- R2: The Send parity bit equals the XOR of the eight data bits (even parity).
- R3: Each `sck_o` low phase and each high phase lasts `half_div`+1 cycles. `line_o` never changes while `sck_o` stays high.
- R4: A Preamble command (`cmd_op`=2) gives 16 rising `sck_o` edges with `line_o` held at 1 and raises no result strobe.
- R5: A Receive command (`cmd_op`=1) holds `line_o` at 1 for 16 bit times and samples `line_i` in each high phase. The start bit is the earliest 0 among sample positions 0 to 3. The next 8 samples are the data, least significant first. `rsp_valid` pulses for one cycle with that byte and `rsp_err`=0 when the frame is well formed.
- R6: If none of sample positions 0 to 3 is 0, `rsp_err`=1 and `rsp_data`=0, even if a 0 appears later in the window.
- R7: If the received parity bit differs from the XOR of the received data bits, `rsp_err`=2. This takes priority over a stop error.
- R8: If either received stop bit is 0 and the parity is correct, `rsp_err`=3.
- R9: A Link test command (`cmd_op`=3) drives 0 for one bit time and then 1 for one bit time. `rsp_err` is 0 if those two samples read 0 and then 1, and 4 otherwise, with `rsp_data`=0.
- R10: While idle, `cmd_ready`=1, `sck_o`=0 and `line_o`=1. `cmd_ready` drops the cycle after a command is accepted. Send and Preamble produce no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | Clock half-period minus one, in system cycles |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_op | input | 2 | 0 send, 1 receive, 2 preamble, 3 link test |
| cmd_data | input | 8 | Byte to send |
| sck_o | output | 1 | Serial clock to target |
| line_o | output | 1 | Master drive on the shared data line |
| line_i | input | 1 | Resolved level of the shared data line |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 8 | Received byte |
| rsp_err | output | 3 | 0 ok, 1 no start, 2 parity, 3 stop, 4 link |

## Verification
The bench places a start bit at the last legal position (3) and one position beyond it (4). A receiver with an off-by-one search window would accept the frame at position 4, or reject the one at position 3. It checks a frame that has both a bad parity bit and a bad stop bit, which exposes a reversed error priority. It also checks a frame with only the second stop bit cleared, which a decoder that tests one stop bit would pass. The link test runs against a target that mirrors the line and against one stuck low, so a swapped drive order or an ignored second sample shows up as a wrong code. Send frames are compared bit by bit at every rising clock at several divider settings, which catches MSB-first ordering, odd parity, and data changed during the high phase.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int FRAME_BITS = 12;
  localparam int WIN_BITS   = 16;
  localparam int START_WIN  = 4;
  localparam int IDX_W      = $clog2(WIN_BITS);

  typedef enum logic [1:0] {OP_SEND = 2'd0, OP_RECV = 2'd1, OP_PRE = 2'd2, OP_LINK = 2'd3} op_e;
  typedef enum logic [2:0] {E_OK = 3'd0, E_NOSTART = 3'd1, E_PARITY = 3'd2,
                            E_STOP = 3'd3, E_LINK = 3'd4} err_e;
endpackage

// File: rtl/sdl_tick.sv
module sdl_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!run || cnt_q == limit) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == limit);
endmodule

// File: rtl/sdl_encode.sv
module sdl_encode
  import sdl_pkg::*;
(
  input  logic [1:0]          op,
  input  logic [7:0]          data,
  output logic [WIN_BITS-1:0] pattern,
  output logic [IDX_W:0]      nbits
);
  always_comb begin
    pattern = '1;
    nbits   = (IDX_W+1)'(WIN_BITS);
    unique case (op_e'(op))
      OP_SEND: begin
        pattern[0]   = 1'b0;
        pattern[8:1] = data;
        pattern[9]   = ^data;
        nbits        = (IDX_W+1)'(FRAME_BITS);
      end
      OP_LINK: begin
        pattern[0] = 1'b0;
        nbits      = (IDX_W+1)'(2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdl_decode.sv
module sdl_decode
  import sdl_pkg::*;
(
  input  logic [1:0]          op,
  input  logic [WIN_BITS-1:0] samp,
  output logic [7:0]          data,
  output logic [2:0]          err
);
  logic [IDX_W-1:0]    pos;
  logic                found;
  logic [WIN_BITS-1:0] aligned;

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int p = START_WIN - 1; p >= 0; p--) begin
      if (!samp[p]) begin
        found = 1'b1;
        pos   = IDX_W'(p);
      end
    end
  end

  assign aligned = samp >> pos;

  always_comb begin
    data = 8'h00;
    err  = E_OK;
    if (op_e'(op) == OP_LINK) begin
      if (samp[0] || !samp[1]) err = E_LINK;
    end else if (!found) begin
      err = E_NOSTART;
    end else begin
      data = aligned[8:1];
      if (aligned[9] != ^aligned[8:1])       err = E_PARITY;
      else if (!aligned[10] || !aligned[11]) err = E_STOP;
    end
  end
endmodule

// File: rtl/sdl_xcvr.sv
module sdl_xcvr
  import sdl_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  output logic             sck_o,
  output logic             line_o,
  input  logic             line_i,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output logic [2:0]       rsp_err
);
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_DONE} st_e;

  st_e                 st_q;
  logic [1:0]          op_q;
  logic [WIN_BITS-1:0] pat_q, samp_q, enc_pat;
  logic [IDX_W:0]      nbits_q, enc_nbits;
  logic [IDX_W-1:0]    idx_q;
  logic                tick, running, last_bit;
  logic [7:0]          dec_data;
  logic [2:0]          dec_err;

  sdl_encode u_enc (.op(cmd_op), .data(cmd_data), .pattern(enc_pat), .nbits(enc_nbits));
  sdl_decode u_dec (.op(op_q), .samp(samp_q), .data(dec_data), .err(dec_err));

  assign running = (st_q == S_LOW) || (st_q == S_HIGH);
  sdl_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(running), .limit(half_div), .tick(tick)
  );

  assign last_bit = ({1'b0, idx_q} == nbits_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      op_q      <= OP_SEND;
      pat_q     <= '1;
      samp_q    <= '1;
      nbits_q   <= '0;
      idx_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
      rsp_err   <= E_OK;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        S_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          pat_q   <= enc_pat;
          nbits_q <= enc_nbits;
          idx_q   <= '0;
          samp_q  <= '1;
          st_q    <= S_LOW;
        end
        S_LOW: if (tick) st_q <= S_HIGH;
        S_HIGH: if (tick) begin
          samp_q[idx_q] <= line_i;
          if (last_bit) st_q <= S_DONE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_LOW;
          end
        end
        S_DONE: begin
          rsp_valid <= (op_e'(op_q) == OP_RECV) || (op_e'(op_q) == OP_LINK);
          rsp_data  <= dec_data;
          rsp_err   <= dec_err;
          st_q      <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st_q == S_IDLE);
  assign sck_o     = (st_q == S_HIGH);
  assign line_o    = running ? pat_q[idx_q] : 1'b1;
endmodule

// File: rtl/sdl_xcvr_chk.sv
module sdl_xcvr_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] half_div,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             sck_o,
  input logic             line_o,
  input logic             rsp_valid,
  input logic [1:0]       op_q
);
  logic [DIV_W:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (sck_o) hi_cnt <= hi_cnt + 1'b1;
    else            hi_cnt <= '0;
  end

  AST_HIGH_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(line_o)); // R3
  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |-> (hi_cnt == {1'b0, half_div} + 1'b1)); // R3
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!sck_o && line_o)); // R10
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R10
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_RECV_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && op_q == 2'd1) |-> line_o); // R5
endmodule

bind sdl_xcvr sdl_xcvr_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .sck_o(sck_o), .line_o(line_o),
  .rsp_valid(rsp_valid), .op_q(op_q)
);

// File: tb/sdl_xcvr_tb.sv
module sdl_xcvr_tb;
  localparam int DIV_W = 8;
  logic clk = 0, rst_n = 0;
  logic [DIV_W-1:0] half_div = '0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_data = 0;
  logic sck_o, line_o, line_i, rsp_valid;
  logic [7:0] rsp_data;
  logic [2:0] rsp_err;

  int checks = 0, errors = 0;
  logic [15:0] tgt_pat = '1;
  int tgt_cnt = 0;
  logic tgt_bit;
  logic sck_prev = 0, line_prev = 1;
  int hi_len = 0;
  logic exp_bits[$];
  logic [10:0] exp_rsp[$];

  always #4 clk = ~clk;

  assign tgt_bit = (tgt_cnt < 16) ? tgt_pat[tgt_cnt] : 1'b1;
  assign line_i  = line_o & tgt_bit;

  sdl_xcvr #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data), .sck_o(sck_o),
    .line_o(line_o), .line_i(line_i), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: line bits at each rising sck, phase width, results
  always @(negedge clk) begin
    if (rst_n) begin
      if (sck_o && !sck_prev) begin
        if (exp_bits.size() == 0) chk(0, "R1 unexpected bit", line_o, 0);
        else begin
          logic e;
          e = exp_bits.pop_front();
          chk(line_o == e, "R1/R2/R4/R5/R9 line bit", line_o, e);
        end
      end
      if (sck_o && sck_prev && line_o != line_prev) chk(0, "R3 line moved in high phase", line_o, line_prev);
      if (sck_o) hi_len++;
      else if (sck_prev) begin
        chk(hi_len == int'(half_div) + 1, "R3 high width", hi_len, int'(half_div) + 1);
        hi_len = 0;
      end
      if (sck_prev && !sck_o) tgt_cnt++;
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) chk(0, "R10 unexpected rsp", rsp_err, 0);
        else begin
          logic [10:0] r;
          r = exp_rsp.pop_front();
          chk({rsp_err, rsp_data} == r, "R5-R9 result", {rsp_err, rsp_data}, r);
        end
      end
    end
    sck_prev  = sck_o;
    line_prev = line_o;
  end

  function automatic logic [15:0] frame(input logic [7:0] d, input int p,
                                        input bit bad_par, input bit bad_stop2);
    logic [15:0] f;
    f = '1;
    f[p] = 1'b0;
    for (int k = 0; k < 8; k++) f[p+1+k] = d[k];
    f[p+9]  = (^d) ^ bad_par;
    f[p+11] = ~bad_stop2;
    return f;
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input int hd,
                         input logic [15:0] tp);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    half_div = DIV_W'(hd);
    tgt_pat  = tp;
    tgt_cnt  = 0;
    case (op)
      2'd0: begin
        exp_bits.push_back(1'b0);
        for (int k = 0; k < 8; k++) exp_bits.push_back(d[k]);
        exp_bits.push_back(^d);
        exp_bits.push_back(1'b1);
        exp_bits.push_back(1'b1);
      end
      2'd3: begin exp_bits.push_back(1'b0); exp_bits.push_back(1'b1); end
      default: for (int k = 0; k < 16; k++) exp_bits.push_back(1'b1);
    endcase
    cmd_op = op; cmd_data = d; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R10 ready drops after accept", cmd_ready, 0);
    while (!cmd_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_bits.size() == 0, "R1/R4/R5 bit count", exp_bits.size(), 0);
    chk(exp_rsp.size() == 0, "R5/R10 result count", exp_rsp.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && !sck_o && line_o && !rsp_valid, "R10 reset idle",
        {cmd_ready, sck_o, line_o, rsp_valid}, 4'b1010);
    rst_n = 1;
    run_cmd(2'd2, 8'h00, 1, '1);                         // R4 preamble
    run_cmd(2'd0, 8'h07, 1, '1);                         // R1 R2 odd count of ones
    run_cmd(2'd0, 8'hA5, 0, '1);                         // R1 R2
    run_cmd(2'd0, 8'h80, 3, '1);                         // R1 R3
    exp_rsp.push_back({3'd0, 8'h80}); run_cmd(2'd1, 0, 1, frame(8'h80, 0, 0, 0)); // R5
    exp_rsp.push_back({3'd0, 8'h3C}); run_cmd(2'd1, 0, 0, frame(8'h3C, 3, 0, 0)); // R5 last pos
    exp_rsp.push_back({3'd1, 8'h00}); run_cmd(2'd1, 0, 1, '1);                    // R6
    exp_rsp.push_back({3'd1, 8'h00}); run_cmd(2'd1, 0, 1, 16'hFFEF);              // R6 pos 4
    exp_rsp.push_back({3'd2, 8'h5A}); run_cmd(2'd1, 0, 1, frame(8'h5A, 1, 1, 0)); // R7
    exp_rsp.push_back({3'd2, 8'hC3}); run_cmd(2'd1, 0, 2, frame(8'hC3, 2, 1, 1)); // R7 priority
    exp_rsp.push_back({3'd3, 8'h11}); run_cmd(2'd1, 0, 1, frame(8'h11, 0, 0, 1)); // R8
    exp_rsp.push_back({3'd0, 8'h00}); run_cmd(2'd3, 0, 1, '1);                    // R9 good
    exp_rsp.push_back({3'd4, 8'h00}); run_cmd(2'd3, 0, 0, '0);                    // R9 stuck low
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule